// File: doc/BRIEF.md
# Scatter-Gather Descriptor Ring Walker

This block follows a ring of transfer descriptors kept in memory. Each descriptor sits in its own 64-byte-aligned slot and holds thirteen 32-bit words. The walker starts at a current pointer and stops after a tail pointer. For each descriptor it reads every word in turn through a word-wide memory port that has one request outstanding at a time. It then hands the buffer address, byte length, frame-boundary flags and application words to a data mover through a command handshake, and waits for the mover to report done. It writes a status word back into the descriptor and follows the descriptor's link word to the next slot.

Software loads the current pointer while the walker is halted and then raises run. After that, each tail-pointer write tells the walker how far it may go. When the tail descriptor has been written back, the walker waits in idle, and the next tail write makes it carry on from the linked descriptor. Cyclic mode lets the walker reuse descriptors that are already marked complete. Any fault stops the walk for good until reset.

States: `ST_HALT` (stopped), `ST_IDLE` (running, nothing pending), `ST_FREQ`/`ST_FRSP` (descriptor word request and response), `ST_CHECK` (validate the fetched descriptor), `ST_CMD` (offer the command), `ST_WAIT` (wait for the mover), `ST_WREQ`/`ST_WRSP` (status write-back request and response), `ST_FAULT` (sticky error).

Transitions:
- HALT→IDLE when run is set.
- IDLE→HALT when run is cleared. IDLE→FREQ when a tail write is pending.
- FREQ→FRSP when the request is accepted.
- FRSP→FREQ on a good response to a word that is not the last. FRSP→CHECK on the last word. FRSP→FAULT on a response error.
- CHECK→FAULT on a stale or zero-length descriptor. Otherwise CHECK→CMD.
- CMD→WAIT when the command is accepted.
- WAIT→WREQ when the mover reports done.
- WREQ→WRSP when the write is accepted.
- WRSP→FAULT on a write error or a mover error. WRSP→HALT when run is low. WRSP→IDLE after the tail descriptor. WRSP→FREQ otherwise.

Top module: `sgr_ring_engine`

## Requirements
- R1: After reset the walker is halted (`halted`=1, `idle`=0) and issues neither memory requests nor commands.
- R2: A current-pointer write takes effect only while halted. A tail-pointer write while halted is ignored. Raising run from halted gives `idle`=1 with no memory traffic until a tail write arrives. `idle` and `halted` are never both 1.
- R3: A descriptor is fetched as 13 word reads at byte offsets 0,4,...,48 from its base, strictly in that order. A request holds its address until it is accepted, and the next request waits for the response.
- R4: The command carries the buffer address from word 2. From the control word (word 6) it takes the length from bits[25:0], start-of-frame from bit 27 and end-of-frame from bit 26. `cmd_app` carries words 8..12 unchanged, with word 8 in bits[31:0] and word 12 in the top 32 bits.
- R5: When the mover reports done, the walker writes the status word at byte offset 28. The word has bit31=1, bit30 = mover decode error, bit29 = mover slave error and bits[25:0] = the mover's byte count. When that write completes, `cmpl_evt` pulses for one cycle.
- R6: The next descriptor is at word 0 with bits[5:0] cleared. The walker processes descriptors up to and including the tail descriptor, then goes idle. A later tail write resumes from the descriptor linked after the old tail.
- R7: A fetched descriptor whose status bit31 is already set causes a fault with no command, unless cyclic mode is on. In cyclic mode the descriptor is processed again.
- R8: A descriptor with length 0 causes a fault and no command is issued.
- R9: A memory response error, or a mover error, raises `err_evt` for exactly one cycle. The walker then stays halted, ignores tail writes and issues no traffic until reset. After a mover error the status is still written and `cmpl_evt` still pulses.
- R10: Clearing run while idle halts the walker on the next cycle. While walking, run is sampled after each write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run (1) / stop (0) |
| cyclic_en | input | 1 | Reuse descriptors already marked complete |
| cur_wr | input | 1 | Current-pointer write strobe |
| cur_val | input | ADDR_W | Current-pointer value |
| tail_wr | input | 1 | Tail-pointer write strobe |
| tail_val | input | ADDR_W | Tail-pointer value |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request ready |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_err | input | 1 | Memory response error |
| mem_rsp_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command ready |
| cmd_addr | output | ADDR_W | Buffer address |
| cmd_len | output | 26 | Buffer length in bytes |
| cmd_sof | output | 1 | Start of frame |
| cmd_eof | output | 1 | End of frame |
| cmd_app | output | APP_N*32 | Application words |
| done_valid | input | 1 | Mover done |
| done_bytes | input | 26 | Bytes moved |
| done_dec_err | input | 1 | Mover decode error |
| done_slv_err | input | 1 | Mover slave error |
| cmpl_evt | output | 1 | Descriptor completion pulse |
| err_evt | output | 1 | Fault pulse |
| idle | output | 1 | Running with nothing pending |
| halted | output | 1 | Stopped or faulted |

## Verification
The bench targets three corner cases.
- The link word in the first descriptor carries junk in its low six bits. A walker that did not mask them would fetch from a misaligned address, and the read-order check would catch it.
- The tail is advanced in two steps, and a tail write is also issued while halted. A walker that lost its position would process the old tail descriptor again. One that acted on a write while halted would produce memory traffic.
- The bench replays descriptors that are already complete, with cyclic mode off and with it on. It also injects a zero length, a mover slave error and a fetch error. A walker that missed any of these would issue a command, stay running, or write a wrong status word. The mover's byte count is made to differ from the programmed length, so a status word built from the control word is caught.

// File: rtl/sgr_pkg.sv
package sgr_pkg;
    localparam int WORD_W       = 32;
    localparam int LEN_W        = 26;
    localparam int SLOT_LSB     = 6;
    localparam int IDX_NEXT     = 0;
    localparam int IDX_BUF      = 2;
    localparam int IDX_CTRL     = 6;
    localparam int IDX_STAT     = 7;
    localparam int IDX_APP0     = 8;
    localparam int BIT_SOF      = 27;
    localparam int BIT_EOF      = 26;
    localparam int BIT_DONE     = 31;
    localparam int BIT_DEC      = 30;
    localparam int BIT_SLV      = 29;

    typedef enum logic [3:0] {
        ST_HALT, ST_IDLE, ST_FREQ, ST_FRSP, ST_CHECK,
        ST_CMD, ST_WAIT, ST_WREQ, ST_WRSP, ST_FAULT
    } sgr_state_e;

    function automatic logic [WORD_W-1:0] sgr_status_word(
        input logic dec, input logic slv, input logic [LEN_W-1:0] bytes);
        logic [WORD_W-1:0] w;
        w = '0;
        w[BIT_DONE] = 1'b1;
        w[BIT_DEC] = dec;
        w[BIT_SLV] = slv;
        w[LEN_W-1:0] = bytes;
        return w;
    endfunction
endpackage

// File: rtl/sgr_ptr_file.sv
module sgr_ptr_file #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cur_load,
    input  logic [ADDR_W-1:0] cur_val,
    input  logic              tail_load,
    input  logic [ADDR_W-1:0] tail_val,
    input  logic              advance,
    input  logic [ADDR_W-1:0] next_ptr,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              pending,
    output logic              at_tail
);
    localparam int LSB = sgr_pkg::SLOT_LSB;

    logic [ADDR_W-1:0] tail_q;
    logic              unused_low;

    function automatic logic [ADDR_W-1:0] slot(input logic [ADDR_W-1:0] v);
        return {v[ADDR_W-1:LSB], {LSB{1'b0}}};
    endfunction

    assign unused_low = ^{cur_val[LSB-1:0], tail_val[LSB-1:0], next_ptr[LSB-1:0]};
    assign at_tail = (cur_ptr == tail_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ptr <= '0;
            tail_q  <= '0;
            pending <= 1'b0;
        end else begin
            if (cur_load)
                cur_ptr <= slot(cur_val);
            else if (advance)
                cur_ptr <= slot(next_ptr);
            if (tail_load) begin
                tail_q  <= slot(tail_val);
                pending <= 1'b1;
            end else if (advance && at_tail) begin
                pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sgr_desc_capture.sv
module sgr_desc_capture #(
    parameter int APP_N = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [3:0]           wr_idx,
    input  logic [31:0]          wr_data,
    output logic [31:0]          next_w,
    output logic [31:0]          buf_w,
    output logic [31:0]          ctrl_w,
    output logic [31:0]          stat_w,
    output logic [APP_N*32-1:0]  app_w
);
    import sgr_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_w <= '0;
            buf_w  <= '0;
            ctrl_w <= '0;
            stat_w <= '0;
        end else if (wr_en) begin
            if (wr_idx == 4'(IDX_NEXT)) next_w <= wr_data;
            if (wr_idx == 4'(IDX_BUF))  buf_w  <= wr_data;
            if (wr_idx == 4'(IDX_CTRL)) ctrl_w <= wr_data;
            if (wr_idx == 4'(IDX_STAT)) stat_w <= wr_data;
        end
    end

    for (genvar k = 0; k < APP_N; k++) begin : g_app
        logic [31:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (wr_en && wr_idx == 4'(IDX_APP0 + k))
                word_q <= wr_data;
        end
        assign app_w[k*32 +: 32] = word_q;
    end
endmodule

// File: rtl/sgr_ring_engine.sv
module sgr_ring_engine #(
    parameter int ADDR_W = 32,
    parameter int APP_N  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_en,
    input  logic                cyclic_en,
    input  logic                cur_wr,
    input  logic [ADDR_W-1:0]   cur_val,
    input  logic                tail_wr,
    input  logic [ADDR_W-1:0]   tail_val,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic                mem_req_write,
    output logic [ADDR_W-1:0]   mem_req_addr,
    output logic [31:0]         mem_req_wdata,
    input  logic                mem_rsp_valid,
    input  logic                mem_rsp_err,
    input  logic [31:0]         mem_rsp_rdata,
    output logic                cmd_valid,
    input  logic                cmd_ready,
    output logic [ADDR_W-1:0]   cmd_addr,
    output logic [25:0]         cmd_len,
    output logic                cmd_sof,
    output logic                cmd_eof,
    output logic [APP_N*32-1:0] cmd_app,
    input  logic                done_valid,
    input  logic [25:0]         done_bytes,
    input  logic                done_dec_err,
    input  logic                done_slv_err,
    output logic                cmpl_evt,
    output logic                err_evt,
    output logic                idle,
    output logic                halted
);
    import sgr_pkg::*;

    localparam int DESC_WORDS = IDX_APP0 + APP_N;
    localparam logic [3:0] LAST_W = 4'(DESC_WORDS - 1);
    localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(IDX_STAT * 4);

    sgr_state_e        state_q, state_d;
    logic [3:0]        wcnt_q;
    logic [LEN_W-1:0]  dbytes_q;
    logic              ddec_q, dslv_q;
    logic [31:0]       next_w, buf_w, ctrl_w, stat_w;
    logic [ADDR_W-1:0] cur_ptr;
    logic              pending, at_tail, advance, cur_load, tail_load;
    logic              mover_err, desc_bad;
    logic              unused_bits;

    assign mover_err = ddec_q | dslv_q;
    assign desc_bad  = (stat_w[BIT_DONE] && !cyclic_en) || (ctrl_w[LEN_W-1:0] == '0);
    assign advance   = (state_q == ST_WRSP) && mem_rsp_valid && !mem_rsp_err && !mover_err;
    assign cur_load  = cur_wr && (state_q == ST_HALT);
    assign tail_load = tail_wr && (state_q != ST_HALT) && (state_q != ST_FAULT);
    assign unused_bits = ^{ctrl_w[31:28], stat_w, next_w, buf_w};

    sgr_ptr_file #(.ADDR_W(ADDR_W)) ptr_i (
        .clk(clk), .rst_n(rst_n),
        .cur_load(cur_load), .cur_val(cur_val),
        .tail_load(tail_load), .tail_val(tail_val),
        .advance(advance), .next_ptr(next_w[ADDR_W-1:0]),
        .cur_ptr(cur_ptr), .pending(pending), .at_tail(at_tail)
    );

    sgr_desc_capture #(.APP_N(APP_N)) cap_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en((state_q == ST_FRSP) && mem_rsp_valid && !mem_rsp_err),
        .wr_idx(wcnt_q), .wr_data(mem_rsp_rdata),
        .next_w(next_w), .buf_w(buf_w), .ctrl_w(ctrl_w), .stat_w(stat_w),
        .app_w(cmd_app)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (run_en) state_d = ST_IDLE;
            ST_IDLE:  if (!run_en) state_d = ST_HALT;
                      else if (pending) state_d = ST_FREQ;
            ST_FREQ:  if (mem_req_ready) state_d = ST_FRSP;
            ST_FRSP:  if (mem_rsp_valid) begin
                          if (mem_rsp_err) state_d = ST_FAULT;
                          else if (wcnt_q == LAST_W) state_d = ST_CHECK;
                          else state_d = ST_FREQ;
                      end
            ST_CHECK: state_d = desc_bad ? ST_FAULT : ST_CMD;
            ST_CMD:   if (cmd_ready) state_d = ST_WAIT;
            ST_WAIT:  if (done_valid) state_d = ST_WREQ;
            ST_WREQ:  if (mem_req_ready) state_d = ST_WRSP;
            ST_WRSP:  if (mem_rsp_valid) begin
                          if (mem_rsp_err || mover_err) state_d = ST_FAULT;
                          else if (!run_en) state_d = ST_HALT;
                          else if (at_tail) state_d = ST_IDLE;
                          else state_d = ST_FREQ;
                      end
            ST_FAULT: state_d = ST_FAULT;
            default:  state_d = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_HALT;
            wcnt_q   <= '0;
            dbytes_q <= '0;
            ddec_q   <= 1'b0;
            dslv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FRSP && mem_rsp_valid)
                wcnt_q <= wcnt_q + 4'd1;
            else if (state_q != ST_FREQ && state_q != ST_FRSP)
                wcnt_q <= '0;
            if (state_q == ST_WAIT && done_valid) begin
                dbytes_q <= done_bytes;
                ddec_q   <= done_dec_err;
                dslv_q   <= done_slv_err;
            end
        end
    end

    always_comb begin
        mem_req_valid = (state_q == ST_FREQ) || (state_q == ST_WREQ);
        mem_req_write = (state_q == ST_WREQ);
        mem_req_addr  = (state_q == ST_WREQ) ? cur_ptr + STAT_OFF
                                             : cur_ptr + ADDR_W'({wcnt_q, 2'b00});
        mem_req_wdata = sgr_status_word(ddec_q, dslv_q, dbytes_q);
        cmd_valid     = (state_q == ST_CMD);
        cmd_addr      = buf_w[ADDR_W-1:0];
        cmd_len       = ctrl_w[LEN_W-1:0];
        cmd_sof       = ctrl_w[BIT_SOF];
        cmd_eof       = ctrl_w[BIT_EOF];
        cmpl_evt      = (state_q == ST_WRSP) && mem_rsp_valid && !mem_rsp_err;
        err_evt       = (state_d == ST_FAULT) && (state_q != ST_FAULT);
        idle          = (state_q == ST_IDLE);
        halted        = (state_q == ST_HALT) || (state_q == ST_FAULT);
    end

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len));
    assert_status_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> mem_req_wdata[BIT_DONE] && mem_req_addr[5:0] == 6'd28);
    assert_cmd_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_len != '0);
    assert_fault_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> halted && !err_evt);
    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !cmd_valid && !mem_req_valid);
    assert_flags_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(idle && halted));
endmodule

// File: tb/sgr_ring_engine_tb_top.sv
`timescale 1ns/1ps
module sgr_ring_engine_tb_top;
    localparam int AW = 32;
    localparam int APPN = 5;
    localparam int APW = APPN * 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic run_en = 0, cyclic_en = 0, cur_wr = 0, tail_wr = 0;
    logic [AW-1:0] cur_val = '0, tail_val = '0;
    logic mem_req_valid, mem_req_write, mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic [31:0] mem_req_wdata, mem_rsp_rdata = '0;
    logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
    logic cmd_valid, cmd_ready = 1'b1, cmd_sof, cmd_eof;
    logic [AW-1:0] cmd_addr;
    logic [25:0] cmd_len, done_bytes = '0;
    logic [APW-1:0] cmd_app;
    logic done_valid = 1'b0, done_dec_err = 1'b0, done_slv_err = 1'b0;
    logic cmpl_evt, err_evt, idle, halted;

    int checks = 0, errors = 0;
    int cmpl_cnt = 0, err_cnt = 0, cmd_cnt = 0, req_cnt = 0, rd_k = 0;
    logic [31:0] mem [0:255];
    logic [AW-1:0] err_addr = '1;
    bit inj_slv = 0;
    int short_by = 0;
    int mv_cnt = 0;
    logic [25:0] mv_len = '0;
    logic [AW-1:0] exp_addr[$];
    logic [25:0] exp_len[$];
    logic [1:0] exp_fl[$];
    logic [APW-1:0] exp_app[$];

    always #4 clk = ~clk;

    sgr_ring_engine #(.ADDR_W(AW), .APP_N(APPN)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cyclic_en(cyclic_en),
        .cur_wr(cur_wr), .cur_val(cur_val), .tail_wr(tail_wr), .tail_val(tail_val),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rsp_rdata(mem_rsp_rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_sof(cmd_sof), .cmd_eof(cmd_eof), .cmd_app(cmd_app),
        .done_valid(done_valid), .done_bytes(done_bytes),
        .done_dec_err(done_dec_err), .done_slv_err(done_slv_err),
        .cmpl_evt(cmpl_evt), .err_evt(err_evt), .idle(idle), .halted(halted)
    );

    task automatic chk(input string tag, input logic [APW-1:0] act, input logic [APW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory responder: one response per accepted request, next cycle
    always @(posedge clk) begin
        mem_req_ready <= ~mem_req_ready;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_err   <= (mem_req_addr == err_addr);
            mem_rsp_rdata <= mem[mem_req_addr[9:2]];
            if (mem_req_write && mem_req_addr != err_addr)
                mem[mem_req_addr[9:2]] <= mem_req_wdata;
        end
    end

    // data mover: done three cycles after the command
    always @(posedge clk) begin
        done_valid <= 1'b0;
        if (mv_cnt != 0) begin
            mv_cnt <= mv_cnt - 1;
            if (mv_cnt == 1) begin
                done_valid   <= 1'b1;
                done_bytes   <= mv_len - 26'(short_by);
                done_slv_err <= inj_slv;
            end
        end
        if (cmd_valid && cmd_ready) begin
            mv_cnt <= 3;
            mv_len <= cmd_len;
        end
    end

    // per-clock reference comparison
    always @(negedge clk) begin
        if (!rst_n) rd_k = 0;
        else begin
            if (cmpl_evt) cmpl_cnt++;
            if (err_evt) err_cnt++;
            if (mem_req_valid && mem_req_ready) begin
                req_cnt++;
                if (mem_req_write) chk("R5 status offset", APW'(mem_req_addr[5:0]), APW'(28));
                else begin
                    chk("R3 fetch order", APW'(mem_req_addr[5:0]), APW'(rd_k * 4));
                    rd_k = (rd_k == 12) ? 0 : rd_k + 1;
                end
            end
            if (cmd_valid && cmd_ready) begin
                cmd_cnt++;
                if (exp_addr.size() == 0) chk("R4 unexpected command", APW'(cmd_addr), '0);
                else begin
                    chk("R4 cmd addr", APW'(cmd_addr), APW'(exp_addr.pop_front()));
                    chk("R4 cmd len", APW'(cmd_len), APW'(exp_len.pop_front()));
                    chk("R4 cmd sof/eof", APW'({cmd_sof, cmd_eof}), APW'(exp_fl.pop_front()));
                    chk("R4 cmd app", cmd_app, exp_app.pop_front());
                end
            end
        end
    end

    task automatic put_desc(input int b, input logic [31:0] nxt, input logic [31:0] bufa,
                            input int len, input bit sof, input bit eof, input logic [31:0] st, input int seed);
        int i = b / 4;
        for (int k = 0; k < 16; k++) mem[i + k] = 32'h0;
        mem[i + 0] = nxt;
        mem[i + 2] = bufa;
        mem[i + 6] = {4'h0, sof, eof, 26'(len)};
        mem[i + 7] = st;
        for (int k = 0; k < APPN; k++) mem[i + 8 + k] = 32'hC0DE0000 | 32'(seed * 256 + k);
    endtask

    task automatic exp_push(input int b);
        int i = b / 4;
        logic [APW-1:0] a;
        for (int k = 0; k < APPN; k++) a[k*32 +: 32] = mem[i + 8 + k];
        exp_addr.push_back(mem[i + 2]);
        exp_len.push_back(mem[i + 6][25:0]);
        exp_fl.push_back(mem[i + 6][27:26]);
        exp_app.push_back(a);
    endtask

    task automatic tail_write(input logic [AW-1:0] v);
        @(negedge clk); tail_val = v; tail_wr = 1'b1;
        @(negedge clk); tail_wr = 1'b0;
    endtask

    task automatic cur_write(input logic [AW-1:0] v);
        @(negedge clk); cur_val = v; cur_wr = 1'b1;
        @(negedge clk); cur_wr = 1'b0;
    endtask

    task automatic wait_cmpl(input int target);
        for (int i = 0; i < 3000 && cmpl_cnt < target; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_err(input int target);
        for (int i = 0; i < 3000 && err_cnt < target; i++) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; run_en = 1'b0; cyclic_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int r0, c0, e0, m0;
        for (int k = 0; k < 256; k++) mem[k] = 32'h0;
        do_reset();
        // R1 reset state
        chk("R1 halted", APW'(halted), APW'(1));
        chk("R1 idle", APW'(idle), APW'(0));
        chk("R1 no request", APW'(mem_req_valid), APW'(0));
        chk("R1 no command", APW'(cmd_valid), APW'(0));

        put_desc(32'h000, 32'h040 | 32'h2A, 32'h1000, 16, 1, 0, 0, 1);
        put_desc(32'h040, 32'h080, 32'h2000, 32, 0, 0, 0, 2);
        put_desc(32'h080, 32'h0C0, 32'h3000, 48, 0, 1, 0, 3);
        put_desc(32'h0C0, 32'h000, 32'h4000, 64, 1, 1, 0, 4);

        // R2 tail write while halted ignored, run gives idle without traffic
        tail_write(32'h080);
        cur_write(32'h000);
        @(negedge clk); run_en = 1'b1;
        repeat (30) @(negedge clk);
        chk("R2 idle after run", APW'(idle), APW'(1));
        chk("R2 no traffic before tail", APW'(req_cnt), APW'(0));

        // R3/R4/R5/R6 walk three descriptors
        exp_push(32'h000); exp_push(32'h040); exp_push(32'h080);
        tail_write(32'h080);
        wait_cmpl(3);
        chk("R5 completions", APW'(cmpl_cnt), APW'(3));
        chk("R6 commands consumed", APW'(exp_addr.size()), APW'(0));
        chk("R5 status d0", APW'(mem[7]), APW'(32'h80000010));
        chk("R5 status d1", APW'(mem[16 + 7]), APW'(32'h80000020));
        chk("R5 status d2", APW'(mem[32 + 7]), APW'(32'h80000030));
        chk("R6 beyond tail untouched", APW'(mem[48 + 7]), APW'(0));
        chk("R3 request count", APW'(req_cnt), APW'(42));
        chk("R6 idle at tail", APW'(idle), APW'(1));

        // R6 resume from next descriptor, byte count from mover
        short_by = 4;
        exp_push(32'h0C0);
        tail_write(32'h0C0);
        wait_cmpl(4);
        chk("R6 resumed status", APW'(mem[48 + 7]), APW'(32'h8000003C));
        chk("R6 single command", APW'(cmd_cnt), APW'(4));
        short_by = 0;

        // R7 cyclic mode reuses completed descriptors
        @(negedge clk); cyclic_en = 1'b1;
        exp_push(32'h000); exp_push(32'h040);
        tail_write(32'h040);
        wait_cmpl(6);
        chk("R7 cyclic no error", APW'(err_cnt), APW'(0));
        chk("R7 cyclic reused", APW'(exp_addr.size()), APW'(0));
        chk("R7 cyclic idle", APW'(idle), APW'(1));
        @(negedge clk); cyclic_en = 1'b0;

        // R10 run drop while idle
        @(negedge clk); run_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 halted", APW'(halted), APW'(1));
        chk("R10 not idle", APW'(idle), APW'(0));
        r0 = req_cnt;
        tail_write(32'h080);
        repeat (10) @(negedge clk);
        chk("R2 halted tail ignored", APW'(req_cnt), APW'(r0));

        // R7 stale descriptor without cyclic
        cur_write(32'h000);
        @(negedge clk); run_en = 1'b1;
        c0 = cmd_cnt; e0 = err_cnt;
        tail_write(32'h000);
        wait_err(e0 + 1);
        chk("R7 stale fault", APW'(err_cnt - e0), APW'(1));
        chk("R7 no command", APW'(cmd_cnt), APW'(c0));
        chk("R9 halted after fault", APW'(halted), APW'(1));
        r0 = req_cnt;
        tail_write(32'h040);
        repeat (20) @(negedge clk);
        chk("R9 sticky no traffic", APW'(req_cnt), APW'(r0));

        // R8 zero length
        do_reset();
        put_desc(32'h100, 32'h140, 32'h5000, 0, 1, 1, 0, 5);
        cur_write(32'h100);
        @(negedge clk); run_en = 1'b1;
        c0 = cmd_cnt; e0 = err_cnt;
        tail_write(32'h100);
        wait_err(e0 + 1);
        chk("R8 zero length fault", APW'(err_cnt - e0), APW'(1));
        chk("R8 no command", APW'(cmd_cnt), APW'(c0));

        // R9 mover slave error
        do_reset();
        put_desc(32'h140, 32'h180, 32'h6000, 8, 1, 1, 0, 6);
        inj_slv = 1; short_by = 3;
        exp_push(32'h140);
        cur_write(32'h140);
        @(negedge clk); run_en = 1'b1;
        m0 = cmpl_cnt; e0 = err_cnt;
        tail_write(32'h140);
        wait_err(e0 + 1);
        chk("R9 mover error status", APW'(mem[80 + 7]), APW'(32'hA0000005));
        chk("R9 completion pulse", APW'(cmpl_cnt - m0), APW'(1));
        chk("R9 single error pulse", APW'(err_cnt - e0), APW'(1));
        chk("R9 halted", APW'(halted), APW'(1));
        inj_slv = 0; short_by = 0;

        // R9 fetch response error
        do_reset();
        put_desc(32'h180, 32'h1C0, 32'h7000, 4, 1, 1, 0, 7);
        err_addr = 32'h188;
        cur_write(32'h180);
        @(negedge clk); run_en = 1'b1;
        c0 = cmd_cnt; e0 = err_cnt;
        tail_write(32'h180);
        wait_err(e0 + 1);
        chk("R9 fetch error pulse", APW'(err_cnt - e0), APW'(1));
        chk("R9 fetch error no command", APW'(cmd_cnt), APW'(c0));
        chk("R9 fetch error halted", APW'(halted), APW'(1));
        err_addr = '1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule